// File: doc/BRIEF.md
# Calendar Time-of-Day Counter with Alarm

This block keeps wall-clock time as a set of binary fields: seconds, minutes, hours, day of week, day of month, month and year. A one-cycle enable pulse, produced elsewhere once per second, advances the seconds field. Carries ripple up through minutes, hours, the day fields, month and year. The day-of-month limit follows the month, and February gains a 29th day in years divisible by four.

Each advance opens an update-in-progress window that lasts a fixed number of clock cycles, chosen to stand for about ten milliseconds. When the window closes, the block emits a one-cycle update-ended pulse. In the same cycle it compares the hour, minute and second fields against three alarm registers and pulses the alarm output if all three agree. An alarm register whose two top bits are both set accepts any value of its field. A set-mode input lets software rewrite the clock without status traffic: while it is high, no window opens, an open window is abandoned, and neither pulse is produced. The time itself keeps counting.

Software loads any time field or alarm register through a single-cycle write strobe with a field select and a data byte. Writes are always accepted, so no back-pressure exists. The next advance continues from the loaded value.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the time reads 00:00:00, weekday 0, day of month 1, month 0, year 0, with `uip`, `upd_done` and `alarm_hit` low and all three alarm registers 0.
- R2: A `tick_1hz` pulse with no write in the same cycle advances seconds by one in the next cycle. Seconds wrap from 59 to 0 and carry into minutes, minutes wrap from 59 to 0 and carry into hours, and hours wrap from 23 to 0 and carry into the day fields.
- R3: Month indices run 0 to 11 with lengths 31, 28, 31, 30, 31, 30, 31, 31, 30, 31, 30, 31. A day carry past the month's last day sets the day of month to 1 and advances the month. Month 11 wraps to 0 and advances the year, and year `YEAR_MAX` (99) wraps to 0.
- R4: In a year whose value is divisible by 4, month 1 has 29 days; otherwise it has 28.
- R5: The weekday advances on every day carry and wraps from 6 to 0.
- R6: An accepted tick while `set_mode` is low drives `uip` high from the next cycle for exactly `UIP_CYCLES` cycles. A further tick inside the window restarts it.
- R7: `upd_done` is a one-cycle pulse in the first cycle after a window in which `uip` is low again.
- R8: In that same cycle `alarm_hit` pulses if and only if each of the hour, minute and second alarm registers either has bits [7:6] = 2'b11 or equals the zero-extended current field.
- R9: While `set_mode` is high, ticks still advance the time, but `uip` goes low within one cycle and stays low, and neither `upd_done` nor `alarm_hit` pulses.
- R10: With `wr_en` high, `wr_sel` loads a field from the low bits of `wr_data`. The codes are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 year, 8 second alarm, 9 minute alarm and 10 hour alarm. Any other code changes nothing.
- R11: A write in the same cycle as a tick takes priority, and the tick is dropped: no field advances and no window opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle advance enable |
| set_mode | input | 1 | Suppresses the update window and its pulses |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 4 | Field select code |
| wr_data | input | 8 | Write data |
| seconds | output | 6 | Seconds, 0 to 59 |
| minutes | output | 6 | Minutes, 0 to 59 |
| hours | output | 5 | Hours, 0 to 23 |
| weekday | output | 3 | Day of week, 0 to 6 |
| mday | output | 5 | Day of month, 1 to 31 |
| month | output | 4 | Month index, 0 to 11 |
| year | output | 7 | Year, 0 to YEAR_MAX |
| uip | output | 1 | Update window open |
| upd_done | output | 1 | Update-ended pulse |
| alarm_hit | output | 1 | Alarm-match pulse |

## Verification
On every cycle, the assertions check the seconds step and its wrap, the load of the seconds field, the dropping of a tick that collides with a write, and the cause of each rising `uip`. They also check that each `upd_done` follows an open window and lasts one cycle, that `alarm_hit` appears only alongside `upd_done`, and that `set_mode` silences the window. The month-length table, leap-year days, weekday wrap, year wrap, the exact window length and the wildcard compare span many fields or many cycles. Only the bench scenarios show these: directed calendar edges and randomized writes, checked against a bench model.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int WDAY_W = 3;
  localparam int MDAY_W = 5;
  localparam int MON_W  = 4;
  localparam int ALM_W  = 8;
  localparam int N_ALM  = 3;

  typedef enum logic [3:0] {
    SEL_SEC   = 4'd0,
    SEL_MIN   = 4'd1,
    SEL_HOUR  = 4'd2,
    SEL_WDAY  = 4'd3,
    SEL_MDAY  = 4'd4,
    SEL_MON   = 4'd5,
    SEL_YEAR  = 4'd6,
    SEL_ASEC  = 4'd8,
    SEL_AMIN  = 4'd9,
    SEL_AHOUR = 4'd10
  } fsel_e;

  // Last valid day of a zero-based month.
  function automatic logic [MDAY_W-1:0] month_len(input logic [MON_W-1:0] mon,
                                                   input logic leap);
    logic [MDAY_W-1:0] d;
    case (mon)
      4'd1:                    d = leap ? 5'd29 : 5'd28;
      4'd3, 4'd5, 4'd8, 4'd10: d = 5'd30;
      default:                 d = 5'd31;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/rtc_wrap_ctr.sv
module rtc_wrap_ctr #(
  parameter int W  = 6,
  parameter int LO = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] top,
  output logic [W-1:0] q,
  output logic         carry
);
  localparam logic [W-1:0] LO_V = W'(LO);

  assign carry = inc && (q >= top);

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= LO_V;
    else if (load)  q <= load_val;
    else if (inc)   q <= carry ? LO_V : q + W'(1);
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_cal_pkg::*;
#(
  parameter int N = N_ALM
) (
  input  logic [N-1:0][ALM_W-1:0] alarm,
  input  logic [N-1:0][ALM_W-1:0] cur,
  output logic                    match
);
  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_fld
    assign hit[i] = (alarm[i][ALM_W-1 -: 2] == 2'b11) || (alarm[i] == cur[i]);
  end

  assign match = &hit;
endmodule

// File: rtl/rtc_upd_window.sv
module rtc_upd_window #(
  parameter int UIP_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  input  logic match_in,
  output logic uip,
  output logic done,
  output logic alarm
);
  localparam int CW = $clog2(UIP_CYCLES + 1);
  localparam logic [CW-1:0] LEN = CW'(UIP_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      done  <= 1'b0;
      alarm <= 1'b0;
    end else begin
      done  <= 1'b0;
      alarm <= 1'b0;
      if (abort) begin
        cnt <= '0;
      end else if (start) begin
        cnt <= LEN;
      end else if (cnt != '0) begin
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          done  <= 1'b1;
          alarm <= match_in;
        end
      end
    end
  end

  assign uip = (cnt != '0);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int UIP_CYCLES = 20,
  parameter int YEAR_W     = 7,
  parameter int YEAR_MAX   = 99
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              set_mode,
  input  logic              wr_en,
  input  logic [3:0]        wr_sel,
  input  logic [7:0]        wr_data,
  output logic [SEC_W-1:0]  seconds,
  output logic [MIN_W-1:0]  minutes,
  output logic [HOUR_W-1:0] hours,
  output logic [WDAY_W-1:0] weekday,
  output logic [MDAY_W-1:0] mday,
  output logic [MON_W-1:0]  month,
  output logic [YEAR_W-1:0] year,
  output logic              uip,
  output logic              upd_done,
  output logic              alarm_hit
);
  localparam logic [YEAR_W-1:0] YEAR_TOP = YEAR_W'(YEAR_MAX);

  logic adv, start_win;
  logic c_sec, c_min, c_hour, c_wday, c_mday, c_mon, c_year;
  logic leap;
  logic [MDAY_W-1:0] day_top;
  logic [N_ALM-1:0][ALM_W-1:0] alm_q, cur_v;
  logic match;

  function automatic logic sel_is(input logic [3:0] s, input fsel_e f);
    return wr_en && (s == f);
  endfunction

  // a write wins over a coincident tick
  assign adv       = tick_1hz && !wr_en;
  assign start_win = adv && !set_mode;
  assign leap      = (year[1:0] == 2'b00);
  assign day_top   = month_len(month, leap);

  rtc_wrap_ctr #(.W(SEC_W), .LO(0)) u_sec (
    .clk(clk), .rst_n(rst_n), .inc(adv), .load(sel_is(wr_sel, SEL_SEC)),
    .load_val(wr_data[SEC_W-1:0]), .top(SEC_W'(59)), .q(seconds), .carry(c_sec));

  rtc_wrap_ctr #(.W(MIN_W), .LO(0)) u_min (
    .clk(clk), .rst_n(rst_n), .inc(c_sec), .load(sel_is(wr_sel, SEL_MIN)),
    .load_val(wr_data[MIN_W-1:0]), .top(MIN_W'(59)), .q(minutes), .carry(c_min));

  rtc_wrap_ctr #(.W(HOUR_W), .LO(0)) u_hour (
    .clk(clk), .rst_n(rst_n), .inc(c_min), .load(sel_is(wr_sel, SEL_HOUR)),
    .load_val(wr_data[HOUR_W-1:0]), .top(HOUR_W'(23)), .q(hours), .carry(c_hour));

  rtc_wrap_ctr #(.W(WDAY_W), .LO(0)) u_wday (
    .clk(clk), .rst_n(rst_n), .inc(c_hour), .load(sel_is(wr_sel, SEL_WDAY)),
    .load_val(wr_data[WDAY_W-1:0]), .top(WDAY_W'(6)), .q(weekday), .carry(c_wday));

  rtc_wrap_ctr #(.W(MDAY_W), .LO(1)) u_mday (
    .clk(clk), .rst_n(rst_n), .inc(c_hour), .load(sel_is(wr_sel, SEL_MDAY)),
    .load_val(wr_data[MDAY_W-1:0]), .top(day_top), .q(mday), .carry(c_mday));

  rtc_wrap_ctr #(.W(MON_W), .LO(0)) u_mon (
    .clk(clk), .rst_n(rst_n), .inc(c_mday), .load(sel_is(wr_sel, SEL_MON)),
    .load_val(wr_data[MON_W-1:0]), .top(MON_W'(11)), .q(month), .carry(c_mon));

  rtc_wrap_ctr #(.W(YEAR_W), .LO(0)) u_year (
    .clk(clk), .rst_n(rst_n), .inc(c_mon), .load(sel_is(wr_sel, SEL_YEAR)),
    .load_val(wr_data[YEAR_W-1:0]), .top(YEAR_TOP), .q(year), .carry(c_year));

  // weekday and year carries have no consumer
  logic unused_carry;
  assign unused_carry = c_wday ^ c_year;

  // alarm registers: index 0 seconds, 1 minutes, 2 hours
  for (genvar i = 0; i < N_ALM; i++) begin : g_alm
    localparam logic [3:0] CODE = 4'(SEL_ASEC) + 4'(i);
    always_ff @(posedge clk) begin
      if (!rst_n)                        alm_q[i] <= '0;
      else if (wr_en && wr_sel == CODE)  alm_q[i] <= wr_data;
    end
  end

  assign cur_v[0] = ALM_W'(seconds);
  assign cur_v[1] = ALM_W'(minutes);
  assign cur_v[2] = ALM_W'(hours);

  rtc_alarm_cmp #(.N(N_ALM)) u_cmp (
    .alarm(alm_q), .cur(cur_v), .match(match));

  rtc_upd_window #(.UIP_CYCLES(UIP_CYCLES)) u_win (
    .clk(clk), .rst_n(rst_n), .start(start_win), .abort(set_mode),
    .match_in(match), .uip(uip), .done(upd_done), .alarm(alarm_hit));

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_1hz,
  input logic       set_mode,
  input logic       wr_en,
  input logic [3:0] wr_sel,
  input logic [7:0] wr_data,
  input logic [5:0] seconds,
  input logic       uip,
  input logic       upd_done,
  input logic       alarm_hit
);
  // R2
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !wr_en) |=> seconds == (($past(seconds) >= 6'd59) ? 6'd0 : $past(seconds) + 6'd1));

  // R10
  sec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 4'd0) |=> seconds == $past(wr_data[5:0]));

  // R11
  collide_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && wr_en && wr_sel != 4'd0) |=> $stable(seconds));

  // R6
  uip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uip) |-> $past(tick_1hz && !set_mode && !wr_en));

  // R7
  done_after_uip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> ($past(uip) && !uip));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> !upd_done);

  // R8
  alarm_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |-> upd_done);

  // R9
  set_silence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_mode |=> (!uip && !upd_done && !alarm_hit));
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (.*);

// File: tb/sim_rtc_calendar.sv
module sim_rtc_calendar;
  localparam int UIPC = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, tick_1hz = 1'b0, set_mode = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [5:0] seconds, minutes;
  logic [4:0] hours, mday;
  logic [2:0] weekday;
  logic [3:0] month;
  logic [6:0] year;
  logic uip, upd_done, alarm_hit;

  rtc_calendar #(.UIP_CYCLES(UIPC)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .set_mode(set_mode),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .seconds(seconds), .minutes(minutes), .hours(hours), .weekday(weekday),
    .mday(mday), .month(month), .year(year),
    .uip(uip), .upd_done(upd_done), .alarm_hit(alarm_hit));

  int checks = 0, fails = 0;
  int m_sec, m_min, m_hr, m_wd, m_md, m_mon, m_yr;
  int a_sec, a_min, a_hr;

  function automatic int mlen(int mon, int yr);
    if (mon == 1) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 3 || mon == 5 || mon == 8 || mon == 10) return 30;
    return 31;
  endfunction

  function automatic void madvance();
    if (m_sec < 59) begin m_sec++; return; end
    m_sec = 0;
    if (m_min < 59) begin m_min++; return; end
    m_min = 0;
    if (m_hr < 23) begin m_hr++; return; end
    m_hr = 0;
    m_wd = (m_wd >= 6) ? 0 : m_wd + 1;
    if (m_md < mlen(m_mon, m_yr)) begin m_md++; return; end
    m_md = 1;
    if (m_mon < 11) begin m_mon++; return; end
    m_mon = 0;
    m_yr = (m_yr >= 99) ? 0 : m_yr + 1;
  endfunction

  function automatic bit fmatch(int a, int v);
    return ((a >> 6) == 3) || (a == v);
  endfunction

  function automatic int alarm_exp();
    return (fmatch(a_sec, m_sec) && fmatch(a_min, m_min) && fmatch(a_hr, m_hr)) ? 1 : 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_time(string req);
    chk({req, " sec"},  int'(seconds), m_sec);
    chk({req, " min"},  int'(minutes), m_min);
    chk({req, " hour"}, int'(hours),   m_hr);
    chk({req, " wday"}, int'(weekday), m_wd);
    chk({req, " mday"}, int'(mday),    m_md);
    chk({req, " mon"},  int'(month),   m_mon);
    chk({req, " year"}, int'(year),    m_yr);
  endtask

  task automatic wr(int sel, int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 4'(sel); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
    case (sel)
      0: m_sec = data & 63;   1: m_min = data & 63;  2: m_hr = data & 31;
      3: m_wd = data & 7;     4: m_md = data & 31;   5: m_mon = data & 15;
      6: m_yr = data & 127;   8: a_sec = data & 255; 9: a_min = data & 255;
      10: a_hr = data & 255;  default: ;
    endcase
  endtask

  task automatic set_time(int h, int mi, int s, int wd, int md, int mo, int y);
    wr(2, h); wr(1, mi); wr(0, s); wr(3, wd); wr(4, md); wr(5, mo); wr(6, y);
  endtask

  // one tick; checks fields, then the window (or its absence)
  task automatic tick_win(string req, bit expect_win);
    int n = 0;
    int stray = 0;
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
    madvance();
    chk_time(req);
    if (expect_win) begin
      while (uip && n < 100) begin n++; @(negedge clk); end
      chk("R6 window length", n, UIPC);
      chk("R7 done at close", int'(upd_done), 1);
      chk("R8 alarm at close", int'(alarm_hit), alarm_exp());
      @(negedge clk);
      chk("R7 done one cycle", int'(upd_done), 0);
    end else begin
      for (int i = 0; i < UIPC + 3; i++) begin
        if (uip || upd_done || alarm_hit) stray++;
        @(negedge clk);
      end
      chk("R9 no window or pulse", stray, 0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_sec = 0; m_min = 0; m_hr = 0; m_wd = 0; m_md = 1; m_mon = 0; m_yr = 0;
    a_sec = 0; a_min = 0; a_hr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_time("R1");
    chk("R1 uip", int'(uip), 0);
    chk("R1 done", int'(upd_done), 0);
    chk("R1 alarm", int'(alarm_hit), 0);

    // R2 seconds step, then full carry to next day; R3 Feb to Mar non-leap; R5 wday wrap
    set_time(23, 59, 58, 6, 28, 1, 1);
    tick_win("R2", 1);
    tick_win("R3 R5 day carry", 1);
    chk("R5 weekday wrapped", int'(weekday), 0);
    chk("R3 non-leap march", int'(month), 2);

    // R4 leap February
    set_time(23, 59, 59, 2, 28, 1, 4);
    tick_win("R4 leap 29th", 1);
    chk("R4 day 29", int'(mday), 29);
    wr(0, 59); wr(1, 59); wr(2, 23);
    tick_win("R4 leap end", 1);

    // R3 thirty-day month and year wrap
    set_time(23, 59, 59, 0, 30, 3, 10);
    tick_win("R3 april end", 1);
    set_time(23, 59, 59, 0, 31, 11, 99);
    tick_win("R3 year wrap", 1);
    chk("R3 year 0", int'(year), 0);

    // R8 alarm exact, wildcard, mismatch
    set_time(12, 30, 44, 1, 5, 5, 20);
    wr(8, 45); wr(9, 30); wr(10, 12);
    tick_win("R8 exact", 1);
    wr(8, 46); wr(10, 8'hC0);
    tick_win("R8 wildcard hour", 1);
    wr(8, 50);
    tick_win("R8 mismatch", 1);
    wr(8, 8'hFF); wr(9, 8'hC5);
    tick_win("R8 all wild", 1);

    // R10 unused codes
    wr(7, 8'h55); wr(15, 8'h11); wr(11, 8'h02);
    chk_time("R10 unused code");
    tick_win("R10 alarms kept", 1);

    // R11 collision
    @(negedge clk);
    tick_1hz = 1'b1; wr_en = 1'b1; wr_sel = 4'd1; wr_data = 8'd33;
    @(negedge clk);
    tick_1hz = 1'b0; wr_en = 1'b0; m_min = 33;
    chk_time("R11 write wins");
    chk("R11 no window", int'(uip), 0);

    // R9 set mode: time counts, no window; abort of open window
    set_mode = 1'b1;
    tick_win("R9 set counts", 0);
    set_mode = 1'b0;
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0; madvance();
    @(negedge clk); set_mode = 1'b1;
    @(negedge clk);
    chk("R9 abort uip", int'(uip), 0);
    begin
      int stray = 0;
      for (int i = 0; i < UIPC + 2; i++) begin
        if (upd_done || alarm_hit) stray++;
        @(negedge clk);
      end
      chk("R9 abort no pulse", stray, 0);
    end
    set_mode = 1'b0;
    chk_time("R9 after abort");

    // random writes near boundaries mixed with ticks
    for (int it = 0; it < 400; it++) begin
      if ($urandom_range(0, 3) == 0) begin
        case ($urandom_range(0, 9))
          0: wr(0, $urandom_range(55, 59));
          1: wr(1, $urandom_range(58, 59));
          2: wr(2, $urandom_range(22, 23));
          3: wr(3, $urandom_range(0, 6));
          4: wr(4, $urandom_range(27, mlen(m_mon, m_yr)));
          5: wr(5, $urandom_range(0, 11));
          6: wr(6, $urandom_range(0, 99));
          7: wr(8, ($urandom_range(0, 1) != 0) ? 8'hC0 : m_sec + 1);
          8: wr(9, ($urandom_range(0, 1) != 0) ? 8'hC0 : m_min);
          default: wr(10, ($urandom_range(0, 1) != 0) ? 8'hC0 : m_hr);
        endcase
      end
      tick_win("R2 random", 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule